// File: doc/BRIEF.md
# MSK Transmit Modulator with Bit-Clock Generator

This block turns a serial transmit bit stream into a continuous-phase minimum-shift-keyed tone, delivered as signed digital sine samples at the master clock rate. It divides the master clock (nominally 3.6864 MHz) by 3072 to make its own 1200 Hz transmit timing clock. The user's logic reads that clock from `st_clk` and presents each new data bit in step with it. The data input and the modulator-enable input each pass through a synchroniser. The synchronised values are then captured together on every rising edge of `st_clk`.

A captured bit of 1 selects the 1200 Hz tone and a captured bit of 0 selects the 1800 Hz tone. The bit period is 1200 bit/s, so a 1 bit spans exactly one tone cycle and a 0 bit spans exactly one and a half. The phase accumulator is never reloaded at bit edges, so the waveform has no phase step when the frequency changes. The captured enable is brought out as `data_sel`, which steers a downstream multiplexer between this modulator (1) and a voice source (0). When the captured enable goes from 0 to 1, the accumulator is cleared, so every data burst starts at phase zero.

The phase is a fraction of a full turn held in `ACC_W` bits. The mark step is not an integer number of units per master clock. The missing fraction is therefore spread across the bit period by a remainder counter, and each bit advances the phase by an exact amount. The sine sample comes from a quarter-wave table that is folded into four quadrants.

Top module: `msk_tx_modulator`

## Requirements
- R1: `st_clk` has a period of exactly `DIV` master clocks and stays high for `DIV/2` of them. Its first rising edge comes on the first master clock edge after reset is released.
- R2: `tx_data` and `tx_en` pass through `SYNC_STAGES` flip-flops. The synchronised values are captured only on the master clock edge where `st_clk` rises, and the captured bit holds for the whole following bit period.
- R3: For each captured bit, the phase advances over the bit period by exactly one full turn when the bit is 1, and by exactly one and a half turns when the bit is 0. `tone_phase` therefore wraps once per 1 bit, and once or twice per 0 bit: once when the bit starts at phase 0, twice when it starts at half a turn.
- R4: The phase is never reloaded at a bit boundary. Measured from the last enable rise, `tone_phase` at each `st_clk` rising edge is exactly 0 or exactly 2^(ACC_W-1), following the running count of 0 bits (even count gives 0, odd count gives 2^(ACC_W-1)).
- R5: On a capture where the enable goes from 0 (previous capture) to 1, `tone_phase` becomes 0 on that edge.
- R6: `data_sel` equals the most recently captured enable (1 = modulator feeds the transmit path, 0 = voice input), and changes only when `st_clk` rises.
- R7: While `rst_n` is low, `tx_sample`, `data_sel` and `st_clk` are 0.
- R8: `tx_sample` is a two's-complement sine of the phase one clock earlier. It is strictly positive when that phase's MSB is 0 and strictly negative when it is 1, and its magnitude never exceeds 2^(SAMP_W-1)-1.
- R9: A change of `tx_data` between `st_clk` rising edges that is undone before the next rising edge has no effect on the tone of the current bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Serial bit to modulate (1 = 1200 Hz, 0 = 1800 Hz) |
| tx_en | input | 1 | Modulator enable request (1 = data, 0 = voice) |
| st_clk | output | 1 | Generated transmit timing clock |
| data_sel | output | 1 | Captured enable, selects the modulator over voice |
| tone_phase | output | ACC_W | Current tone phase, a fraction of a full turn |
| tx_sample | output | SAMP_W | Signed sine sample |

## Verification
The bench builds the block with `DIV=48`, `ACC_W=16`, `LUT_AW=5`, `SAMP_W=10` and `SYNC_STAGES=2`. With these values a bit lasts only 48 clocks, so about twenty bits fit into a short run, including two enable bursts, a voice interval and mid-bit glitches on the data input. They also make the mark step 1365 rem 16, a fractional step, so the remainder path is exercised, while the space step is an exact 2048. This lets the exact boundary phase of 0 or 32768 and the one- or two-wrap counts show whether the fraction has been spread correctly.

// File: rtl/msk_pkg.sv
package msk_pkg;

   localparam real HALF_PI = 1.5707963267948966;

   // Bit value that selects the lower (one cycle per bit) tone.
   typedef enum logic {
      TONE_HIGH = 1'b0,
      TONE_LOW  = 1'b1
   } tone_e;

   // Magnitude of a quarter-wave table entry, sampled at the middle of its step.
   function automatic int quarter_sine(input int idx, input int entries, input int amp);
      real ang;
      ang = (real'(idx) + 0.5) * HALF_PI / real'(entries);
      return $rtoi(real'(amp) * $sin(ang) + 0.5);
   endfunction

endpackage

// File: rtl/msk_st_divider.sv
module msk_st_divider #(
   parameter int DIV = 3072
) (
   input  logic clk,
   input  logic rst_n,
   output logic st_clk,
   output logic st_tick
);
   localparam int CNT_W = $clog2(DIV);
   localparam int HALF  = DIV / 2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   initial begin : div_param_chk
      assert (DIV >= 4 && (DIV % 2) == 0)
         else $error("DIV must be even and at least 4");
   end

   assign st_tick = (cnt == CNT_W'(DIV - 1));
   assign cnt_nxt = st_tick ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= CNT_W'(DIV - 1);
         st_clk <= 1'b0;
      end else begin
         cnt    <= cnt_nxt;
         st_clk <= (cnt_nxt < CNT_W'(HALF));
      end
   end

   // R1
   st_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_clk) |-> (cnt == '0));
endmodule

// File: rtl/msk_in_sync.sv
module msk_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   initial begin : sync_param_chk
      assert (STAGES >= 1) else $error("STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) d_out <= 1'b0;
            else        d_out <= d_in;
         end
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_in};
         end
         assign d_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/msk_phase_acc.sv
module msk_phase_acc #(
   parameter int DIV   = 3072,
   parameter int ACC_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  msk_pkg::tone_e   tone,
   output logic [ACC_W-1:0] phase
);
   // Phase per bit: two half turns for the low tone, three for the high tone.
   localparam longint unsigned LOW_NUM   = 64'd2 << (ACC_W - 1);
   localparam longint unsigned HIGH_NUM  = 64'd3 << (ACC_W - 1);
   localparam longint unsigned LOW_BASE  = LOW_NUM / DIV;
   localparam longint unsigned LOW_FRAC  = LOW_NUM % DIV;
   localparam longint unsigned HIGH_BASE = HIGH_NUM / DIV;
   localparam longint unsigned HIGH_FRAC = HIGH_NUM % DIV;
   localparam int ERR_W = $clog2(DIV) + 1;

   logic [ACC_W-1:0] base;

   initial begin : acc_param_chk
      assert (ACC_W >= 8 && ACC_W <= 48) else $error("ACC_W out of range");
   end

   assign base = (tone == msk_pkg::TONE_LOW) ? ACC_W'(LOW_BASE) : ACC_W'(HIGH_BASE);

   generate
      if (LOW_FRAC == 0 && HIGH_FRAC == 0) begin : g_exact
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase <= '0;
            else if (restart) phase <= '0;
            else              phase <= phase + base;
         end
      end else begin : g_dither
         logic [ERR_W-1:0] err;
         logic [ERR_W:0]   frac;
         logic [ERR_W:0]   err_sum;
         logic             carry;

         assign frac    = (tone == msk_pkg::TONE_LOW) ? (ERR_W+1)'(LOW_FRAC)
                                                      : (ERR_W+1)'(HIGH_FRAC);
         assign err_sum = {1'b0, err} + frac;
         assign carry   = (err_sum >= (ERR_W+1)'(DIV));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
               err   <= '0;
            end else if (restart) begin
               phase <= '0;
               err   <= '0;
            end else begin
               phase <= phase + base + ACC_W'(carry);
               err   <= carry ? ERR_W'(err_sum - (ERR_W+1)'(DIV)) : ERR_W'(err_sum);
            end
         end

         // R3
         err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err < ERR_W'(DIV));
      end
   endgenerate
endmodule

// File: rtl/msk_sine_lut.sv
module msk_sine_lut #(
   parameter int LUT_AW = 6,
   parameter int SAMP_W = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LUT_AW+1:0]        phase_top,
   output logic signed [SAMP_W-1:0] sample
);
   localparam int ENTRIES = 1 << LUT_AW;
   localparam int MAG_W   = SAMP_W - 1;
   localparam int AMP     = (1 << MAG_W) - 1;

   logic [MAG_W-1:0]  lut [ENTRIES];
   logic [1:0]        quad;
   logic [LUT_AW-1:0] idx;
   logic [LUT_AW-1:0] addr;
   logic [SAMP_W-1:0] mag_ext;
   logic [SAMP_W-1:0] value;

   initial begin : lut_param_chk
      assert (SAMP_W >= 4 && LUT_AW >= 2 && LUT_AW <= 10)
         else $error("sine table size out of range");
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
      assign lut[i] = MAG_W'(msk_pkg::quarter_sine(i, ENTRIES, AMP));
   end

   assign quad    = phase_top[LUT_AW+1:LUT_AW];
   assign idx     = phase_top[LUT_AW-1:0];
   assign addr    = quad[0] ? ~idx : idx;
   assign mag_ext = {1'b0, lut[addr]};
   assign value   = quad[1] ? (~mag_ext + 1'b1) : mag_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample <= '0;
      else        sample <= $signed(value);
   end

   // R8
   neg_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_top[LUT_AW+1] |=> (sample < 0));
   // R8
   pos_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_top[LUT_AW+1] |=> (sample > 0));
endmodule

// File: rtl/msk_tx_modulator.sv
module msk_tx_modulator #(
   parameter int DIV         = 3072,
   parameter int ACC_W       = 24,
   parameter int LUT_AW      = 6,
   parameter int SAMP_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tx_data,
   input  logic                     tx_en,
   output logic                     st_clk,
   output logic                     data_sel,
   output logic [ACC_W-1:0]         tone_phase,
   output logic signed [SAMP_W-1:0] tx_sample
);
   logic           st_tick;
   logic           data_sync;
   logic           en_sync;
   logic           restart;
   msk_pkg::tone_e bit_q;

   initial begin : top_param_chk
      assert (ACC_W >= LUT_AW + 2) else $error("ACC_W too narrow for table");
      assert (SYNC_STAGES * 2 < DIV) else $error("synchroniser longer than half a bit");
   end

   msk_st_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .st_clk(st_clk), .st_tick(st_tick));

   msk_in_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .d_in(tx_data), .d_out(data_sync));

   msk_in_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d_in(tx_en), .d_out(en_sync));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q    <= msk_pkg::TONE_HIGH;
         data_sel <= 1'b0;
      end else if (st_tick) begin
         bit_q    <= msk_pkg::tone_e'(data_sync);
         data_sel <= en_sync;
      end
   end

   assign restart = st_tick && en_sync && !data_sel;

   msk_phase_acc #(.DIV(DIV), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tone(bit_q), .phase(tone_phase));

   msk_sine_lut #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_sine (
      .clk(clk), .rst_n(rst_n),
      .phase_top(tone_phase[ACC_W-1 -: LUT_AW+2]), .sample(tx_sample));

   // R2
   bit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bit_q) |-> $rose(st_clk));
   // R6
   sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_sel) |-> $rose(st_clk));
   // R5
   burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_sel) |-> (tone_phase == '0));
endmodule

// File: tb/msk_tx_modulator_tb.sv
module msk_tx_modulator_tb;
   localparam int DIV    = 48;
   localparam int ACC_W  = 16;
   localparam int LUT_AW = 5;
   localparam int SAMP_W = 10;
   localparam int SYNC   = 2;
   localparam int HALFT  = 1 << (ACC_W - 1);
   localparam int AMP    = (1 << (SAMP_W - 1)) - 1;
   localparam int NITEMS = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_data = 1'b0;
   logic tx_en = 1'b0;
   logic st_clk;
   logic data_sel;
   logic [ACC_W-1:0] tone_phase;
   logic signed [SAMP_W-1:0] tx_sample;

   int checks = 0;
   int fails = 0;
   bit mon_stop = 1'b0;
   bit finished = 1'b0;
   logic [1:0] exp_q[$];   // {enable, data}

   // {enable, data} per bit period
   logic [1:0] seq [NITEMS] = '{2'b01, 2'b11, 2'b11, 2'b10, 2'b10, 2'b10, 2'b11, 2'b10,
                                2'b11, 2'b11, 2'b00, 2'b01, 2'b10, 2'b10, 2'b11, 2'b10};

   always #4 clk = ~clk;

   msk_tx_modulator #(.DIV(DIV), .ACC_W(ACC_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W),
                      .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_en(tx_en),
      .st_clk(st_clk), .data_sel(data_sel), .tone_phase(tone_phase), .tx_sample(tx_sample));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Driver: new item one clock after each st_clk fall, some with a mid-bit glitch.
   initial begin
      exp_q.push_back(2'b00);   // first capture sees reset synchronisers
      repeat (3) @(negedge clk);
      chk(tx_sample == 0, "R7 sample in reset", int'(tx_sample), 0);
      chk(data_sel == 1'b0, "R7 sel in reset", int'(data_sel), 0);
      chk(st_clk == 1'b0, "R7 st in reset", int'(st_clk), 0);
      rst_n = 1'b1;
      for (int i = 0; i < NITEMS; i++) begin
         @(negedge st_clk);
         @(negedge clk);
         tx_en   = seq[i][1];
         tx_data = seq[i][0];
         exp_q.push_back(seq[i]);
         if (i % 3 == 1) begin   // R9 glitch undone before the next capture
            repeat (4) @(negedge clk);
            tx_data = ~seq[i][0];
            repeat (4) @(negedge clk);
            tx_data = seq[i][0];
         end
      end
      @(posedge st_clk);
      repeat (2) @(negedge clk);
      mon_stop = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      chk(tx_sample == 0, "R7 sample after reset", int'(tx_sample), 0);
      chk(data_sel == 1'b0, "R7 sel after reset", int'(data_sel), 0);
      chk(st_clk == 1'b0, "R7 st after reset", int'(st_clk), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // Monitor: pops one item per capture and compares phase, wraps, select and samples.
   initial begin
      int cyc;
      int last_rise;
      bit have_rise;
      bit st_prev;
      bit prev_ok;
      logic [ACC_W-1:0] prev_phase;
      bit model_ok;
      bit start_half;
      bit cur_bit;
      bit en_prev;
      int wraps;
      int exp_w;
      logic [1:0] it;
      cyc = 0; last_rise = 0; have_rise = 0; st_prev = 0; prev_ok = 0;
      prev_phase = '0; model_ok = 0; start_half = 0; cur_bit = 0; en_prev = 0; wraps = 0;
      wait (rst_n === 1'b1);
      while (!mon_stop) begin
         @(negedge clk);
         if (mon_stop) break;
         cyc++;
         if (prev_ok && tone_phase < prev_phase) wraps++;
         if (prev_ok) begin
            chk((tx_sample < 0) == prev_phase[ACC_W-1], "R8 sample sign",
                int'(tx_sample), prev_phase[ACC_W-1] ? -1 : 1);
            chk(tx_sample <= AMP && tx_sample >= -AMP, "R8 sample range", int'(tx_sample), AMP);
         end
         if (st_clk && !st_prev) begin
            if (have_rise) chk(cyc - last_rise == DIV, "R1 st period", cyc - last_rise, DIV);
            last_rise = cyc;
            have_rise = 1;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 queue empty at capture", 0, 1);
               it = 2'b00;
            end else begin
               it = exp_q.pop_front();
            end
            chk(data_sel == it[1], "R6 data_sel", int'(data_sel), int'(it[1]));
            if (it[1] && !en_prev) begin
               chk(tone_phase == 0, "R5 phase restart", int'(tone_phase), 0);
               model_ok = 1;
               start_half = 0;
            end else if (model_ok) begin
               exp_w = cur_bit ? 1 : (start_half ? 2 : 1);
               chk(wraps == exp_w, cur_bit ? "R3 wraps low tone R2 R9" : "R3 wraps high tone R2 R9",
                   wraps, exp_w);
               if (!cur_bit) start_half = ~start_half;
               chk(tone_phase == (start_half ? HALFT : 0), "R4 boundary phase",
                   int'(tone_phase), start_half ? HALFT : 0);
            end
            cur_bit = it[0];
            en_prev = it[1];
            wraps = 0;
         end
         if (!st_clk && st_prev)
            chk(cyc - last_rise == DIV / 2, "R1 st high time", cyc - last_rise, DIV / 2);
         st_prev = st_clk;
         prev_phase = tone_phase;
         prev_ok = 1;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule